// File: doc/BRIEF.md
# Descriptor ring doorbell controller

This block is the register front end of a descriptor-driven bus master. Software fills ring slots in memory. It then moves a producer index (the head) inside a control word and sets a run bit. The block holds its own consumer index (the tail). While the run bit is set and the two indices differ, it offers the tail index to a downstream executor. The executor reports each finished descriptor with a one-cycle completion pulse that carries a success flag and a per-descriptor interrupt flag. On each accepted completion the tail moves forward one slot, wrapping after the programmed last slot.

The block keeps two sticky flags, one for interrupting completions and one for errors. Software clears them by writing ones. The interrupt line is the OR of the completion flag and the error flag, where the error flag only counts when its enable is set. A write-only command word gives software three actions: a soft clear of all state, a kill that abandons the descriptor in flight, and a one-cycle reset pulse for the attached bus targets. Register access uses a plain 32-bit port with a 2-bit word select, synchronous writes and combinational reads.

Top module: `ring_doorbell`

## Requirements
- R1: After reset, all four registers read zero, `reqValid` is 0 and `irq` is 0.
- R2: The control word (select 1) stores the run bit at bit 0, the error interrupt enable at bit 4 and the head index in a PTR_W-bit field starting at bit 16. The ring-size word (select 3) stores the last slot number (entries minus one) in its low PTR_W bits. All other bits read zero, and the command word (select 0) always reads zero.
- R3: `reqValid` is high exactly when the run bit is set and head differs from tail. `reqIndex` always shows the tail, and status bit 0 (select 2) mirrors `reqValid`.
- R4: A completion accepted while `reqValid` is high advances the tail by one. A tail equal to the ring-size value wraps to 0. The tail reads back in a PTR_W-bit field starting at bit 16 of the status word.
- R5: An accepted completion with `cmplOk`=1 and `cmplIrq`=1 sets the completion flag (status bit 5). With `cmplIrq`=0 the flag is left unchanged.
- R6: An accepted completion with `cmplOk`=0 sets the error flag (status bit 4), advances the tail and clears the run bit. The run bit clears even if software writes it in the same cycle.
- R7: Writing a 1 to status bit 5 or bit 4 clears that flag, and writing 0 leaves it. A flag being set in the same cycle as its clear wins over the clear.
- R8: `irq` equals the completion flag OR (the error flag AND the error interrupt enable).
- R9: A completion pulse while `reqValid` is low is ignored: tail and flags stay unchanged.
- R10: Writing command bit 3 (kill) sets the error flag and clears the run bit. If a request is pending, it also pulses `abortPulse` in the write cycle and advances the tail past the abandoned slot. If no request is pending, `abortPulse` stays low and the tail does not move.
- R11: Writing command bit 6 (soft clear) returns head, tail, size, run bit, enable and both flags to zero at the next edge. It overrides any other event in that cycle.
- R12: Writing command bit 2 raises `busResetPulse` in the write cycle only, and register state is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Word select: 0 command, 1 control, 2 status, 3 ring size |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data of the selected word (combinational) |
| reqValid | output | 1 | A descriptor is pending for the executor |
| reqIndex | output | PTR_W | Slot index of the pending descriptor (the tail) |
| cmplValid | input | 1 | One-cycle completion pulse from the executor |
| cmplOk | input | 1 | Completion succeeded |
| cmplIrq | input | 1 | Completed descriptor requests an interrupt |
| abortPulse | output | 1 | Kill abandoned the pending descriptor |
| busResetPulse | output | 1 | Reset pulse for attached bus targets |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with PTR_W=4, so the head and tail fields are 4 bits at bits 19:16. It programs a four-slot ring. This makes the wrap from the last slot back to slot 0 reachable within a few completions, and it is exercised with the head placed both before and after the wrap point. The narrow field also leaves upper data bits that the design must drop, which the readback checks cover. Completions are issued with every success and interrupt-flag combination, during idle periods, and in the same cycle as flag clears and control writes. This exposes the precedence rules between hardware events and software writes.

// File: rtl/ring_doorbell_pkg.sv
package ring_doorbell_pkg;

  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    REG_GCTL = 2'd0,
    REG_CTRL = 2'd1,
    REG_STAT = 2'd2,
    REG_SIZE = 2'd3
  } regSel_e;

  // control word
  localparam int RUN_BIT   = 0;
  localparam int EIE_BIT   = 4;
  localparam int PTR_LSB   = 16;
  // status word
  localparam int BUSY_BIT  = 0;
  localparam int ERR_BIT   = 4;
  localparam int DONE_BIT  = 5;
  // command word
  localparam int TRST_BIT  = 2;
  localparam int KILL_BIT  = 3;
  localparam int SRST_BIT  = 6;

  typedef struct packed {
    logic softClr;
    logic advTail;
    logic setDone;
    logic setErr;
    logic stopRun;
  } ringStrobe_t;

endpackage

// File: rtl/ring_doorbell_ctrl.sv
module ring_doorbell_ctrl
  import ring_doorbell_pkg::*;
(
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [REG_W-1:0] regWrData,
  input  logic             cmplValid,
  input  logic             cmplOk,
  input  logic             cmplIrq,
  input  logic             pending,
  output ringStrobe_t      stb,
  output logic             abortPulse,
  output logic             busResetPulse
);

  logic gctlWr;
  logic killReq;
  logic accept;
  logic unusedWr;

  assign unusedWr = ^regWrData;

  always_comb begin
    gctlWr        = regWrEn && (regAddr == REG_GCTL);
    stb.softClr   = gctlWr && regWrData[SRST_BIT];
    killReq       = gctlWr && regWrData[KILL_BIT] && !stb.softClr;
    accept        = cmplValid && pending && !killReq && !stb.softClr;
    stb.advTail   = (killReq && pending) || accept;
    stb.setDone   = accept && cmplOk && cmplIrq;
    stb.setErr    = killReq || (accept && !cmplOk);
    stb.stopRun   = stb.setErr;
    abortPulse    = killReq && pending;
    busResetPulse = gctlWr && regWrData[TRST_BIT];
  end

endmodule

// File: rtl/ring_doorbell_regs.sv
module ring_doorbell_regs
  import ring_doorbell_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [REG_W-1:0] regWrData,
  input  ringStrobe_t      stb,
  output logic             pending,
  output logic [PTR_W-1:0] tailIdx,
  output logic             irqOut,
  output logic [REG_W-1:0] regRdData
);

  localparam logic [PTR_W-1:0] PTR_ONE = {{(PTR_W-1){1'b0}}, 1'b1};

  logic [PTR_W-1:0] headPtr;
  logic [PTR_W-1:0] tailPtr;
  logic [PTR_W-1:0] lastSlot;
  logic [PTR_W-1:0] nextTail;
  logic             runBit;
  logic             errIe;
  logic             doneFlag;
  logic             errFlag;
  logic             ctrlWr;
  logic             statWr;
  logic             sizeWr;
  logic             unusedWr;

  assign unusedWr = ^regWrData;
  assign ctrlWr   = regWrEn && (regAddr == REG_CTRL);
  assign statWr   = regWrEn && (regAddr == REG_STAT);
  assign sizeWr   = regWrEn && (regAddr == REG_SIZE);
  assign nextTail = (tailPtr == lastSlot) ? '0 : tailPtr + PTR_ONE;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPtr  <= '0;
      tailPtr  <= '0;
      lastSlot <= '0;
      runBit   <= 1'b0;
      errIe    <= 1'b0;
      doneFlag <= 1'b0;
      errFlag  <= 1'b0;
    end else if (stb.softClr) begin
      headPtr  <= '0;
      tailPtr  <= '0;
      lastSlot <= '0;
      runBit   <= 1'b0;
      errIe    <= 1'b0;
      doneFlag <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      if (stb.advTail) tailPtr <= nextTail;
      if (ctrlWr) begin
        runBit  <= regWrData[RUN_BIT];
        errIe   <= regWrData[EIE_BIT];
        headPtr <= regWrData[PTR_LSB +: PTR_W];
      end
      if (stb.stopRun) runBit <= 1'b0;
      if (sizeWr) lastSlot <= regWrData[PTR_W-1:0];
      if (statWr && regWrData[DONE_BIT]) doneFlag <= 1'b0;
      if (stb.setDone) doneFlag <= 1'b1;
      if (statWr && regWrData[ERR_BIT]) errFlag <= 1'b0;
      if (stb.setErr) errFlag <= 1'b1;
    end
  end

  assign pending = runBit && (headPtr != tailPtr);
  assign tailIdx = tailPtr;
  assign irqOut  = doneFlag || (errFlag && errIe);

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      REG_CTRL: begin
        regRdData[RUN_BIT]             = runBit;
        regRdData[EIE_BIT]             = errIe;
        regRdData[PTR_LSB +: PTR_W]    = headPtr;
      end
      REG_STAT: begin
        regRdData[BUSY_BIT]            = pending;
        regRdData[ERR_BIT]             = errFlag;
        regRdData[DONE_BIT]            = doneFlag;
        regRdData[PTR_LSB +: PTR_W]    = tailPtr;
      end
      REG_SIZE: regRdData[PTR_W-1:0]   = lastSlot;
      default:  regRdData              = '0;
    endcase
  end

endmodule

// File: rtl/ring_doorbell.sv
module ring_doorbell
  import ring_doorbell_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData,
  output logic             reqValid,
  output logic [PTR_W-1:0] reqIndex,
  input  logic             cmplValid,
  input  logic             cmplOk,
  input  logic             cmplIrq,
  output logic             abortPulse,
  output logic             busResetPulse,
  output logic             irq
);

  ringStrobe_t strobes;
  logic        pendingNow;

  ring_doorbell_ctrl u_ctrl (
    .regWrEn      (regWrEn),
    .regAddr      (regAddr),
    .regWrData    (regWrData),
    .cmplValid    (cmplValid),
    .cmplOk       (cmplOk),
    .cmplIrq      (cmplIrq),
    .pending      (pendingNow),
    .stb          (strobes),
    .abortPulse   (abortPulse),
    .busResetPulse(busResetPulse)
  );

  ring_doorbell_regs #(.PTR_W(PTR_W)) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .stb      (strobes),
    .pending  (pendingNow),
    .tailIdx  (reqIndex),
    .irqOut   (irq),
    .regRdData(regRdData)
  );

  assign reqValid = pendingNow;

endmodule

// File: rtl/ring_doorbell_checker.sv
module ring_doorbell_checker #(
  parameter int PTR_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic [1:0]       regAddr,
  input logic [31:0]      regWrData,
  input logic             reqValid,
  input logic [PTR_W-1:0] reqIndex,
  input logic             cmplValid,
  input logic             cmplOk,
  input logic             cmplIrq,
  input logic             abortPulse,
  input logic             irq
);

  logic gctlWr;
  logic anyWr;
  logic unusedWr;

  assign gctlWr   = regWrEn && (regAddr == 2'd0);
  assign anyWr    = regWrEn;
  assign unusedWr = ^regWrData;

  // R3: the offered index holds while nothing can move the tail
  p_idx_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!cmplValid && !gctlWr) |=> $stable(reqIndex));

  // R9: a completion without a pending request leaves the tail alone
  p_idle_ignores_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!reqValid && cmplValid && !gctlWr) |=> $stable(reqIndex));

  // R5: an interrupting success raises the interrupt line next cycle
  p_done_raises_irq_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && cmplValid && cmplOk && cmplIrq && !gctlWr) |=> irq);

  // R6: a failed descriptor stops the ring
  p_fail_stops_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && cmplValid && !cmplOk && !gctlWr) |=> !reqValid);

  // R10: abort only for a pending descriptor, and processing stops after it
  p_abort_needs_req_r10: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |-> reqValid);
  p_abort_stops_r10: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |=> !reqValid);

  // R11: soft clear leaves an idle, quiet ring at slot zero
  p_soft_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    (gctlWr && regWrData[6]) |=> (!reqValid && !irq && (reqIndex == '0)));

  // R1: nothing is requested while reset is held
  always_comb begin
    if (!rstN) begin
      p_reset_idle_r1: assert (!reqValid || $isunknown(reqValid));
    end
  end

  logic unusedIn;
  assign unusedIn = anyWr;

endmodule

bind ring_doorbell ring_doorbell_checker #(.PTR_W(PTR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .reqValid  (reqValid),
  .reqIndex  (reqIndex),
  .cmplValid (cmplValid),
  .cmplOk    (cmplOk),
  .cmplIrq   (cmplIrq),
  .abortPulse(abortPulse),
  .irq       (irq)
);

// File: tb/ring_doorbell_test.sv
module ring_doorbell_test;

  localparam int PTR_W = 4;
  localparam int PMASK = (1 << PTR_W) - 1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             regWrEn = 1'b0;
  logic [1:0]       regAddr = 2'd0;
  logic [31:0]      regWrData = '0;
  logic [31:0]      regRdData;
  logic             reqValid;
  logic [PTR_W-1:0] reqIndex;
  logic             cmplValid = 1'b0;
  logic             cmplOk = 1'b0;
  logic             cmplIrq = 1'b0;
  logic             abortPulse;
  logic             busResetPulse;
  logic             irq;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  ring_doorbell #(.PTR_W(PTR_W)) uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .reqValid(reqValid),
    .reqIndex(reqIndex), .cmplValid(cmplValid), .cmplOk(cmplOk),
    .cmplIrq(cmplIrq), .abortPulse(abortPulse),
    .busResetPulse(busResetPulse), .irq(irq)
  );

  always #5 clk = ~clk;

  // behavioural reference state
  int mHead = 0, mTail = 0, mSize = 0;
  int mRun = 0, mEie = 0, mDone = 0, mErr = 0;

  function automatic int mPend();
    return (mRun != 0 && mHead != mTail) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mHead = 0; mTail = 0; mSize = 0; mRun = 0; mEie = 0; mDone = 0; mErr = 0;
    end else if (regWrEn && regAddr == 2'd0 && regWrData[6]) begin
      mHead = 0; mTail = 0; mSize = 0; mRun = 0; mEie = 0; mDone = 0; mErr = 0;
    end else begin
      int pend, kill, acc, newTail, setD, setE;
      pend = mPend();
      kill = (regWrEn && regAddr == 2'd0 && regWrData[3]) ? 1 : 0;
      acc  = (cmplValid && pend != 0 && kill == 0) ? 1 : 0;
      newTail = mTail;
      if ((kill != 0 && pend != 0) || acc != 0)
        newTail = (mTail == mSize) ? 0 : ((mTail + 1) & PMASK);
      setD = (acc != 0 && cmplOk && cmplIrq) ? 1 : 0;
      setE = (kill != 0 || (acc != 0 && !cmplOk)) ? 1 : 0;
      if (regWrEn && regAddr == 2'd2) begin
        if (regWrData[5]) mDone = 0;
        if (regWrData[4]) mErr = 0;
      end
      if (setD != 0) mDone = 1;
      if (setE != 0) mErr = 1;
      if (regWrEn && regAddr == 2'd1) begin
        mRun  = regWrData[0];
        mEie  = regWrData[4];
        mHead = (regWrData >> 16) & PMASK;
      end
      if (setE != 0) mRun = 0;
      if (regWrEn && regAddr == 2'd3) mSize = regWrData & PMASK;
      mTail = newTail;
    end
  end

  task automatic cmpField(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-clock comparison against the reference model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      logic [31:0] expRd;
      logic expAbort, expBrst;
      case (regAddr)
        2'd1: expRd = (32'(mHead) << 16) | (32'(mEie) << 4) | 32'(mRun);
        2'd2: expRd = (32'(mTail) << 16) | (32'(mDone) << 5) | (32'(mErr) << 4) | 32'(mPend());
        2'd3: expRd = 32'(mSize);
        default: expRd = '0;
      endcase
      expAbort = regWrEn && regAddr == 2'd0 && regWrData[3] && !regWrData[6] && mPend() != 0;
      expBrst  = regWrEn && regAddr == 2'd0 && regWrData[2];
      cmpField("R3 reqValid", {31'd0, reqValid}, 32'(mPend()));
      cmpField("R3 reqIndex", 32'(reqIndex), 32'(mTail));
      cmpField("R8 irq", {31'd0, irq}, 32'(mDone != 0 || (mErr != 0 && mEie != 0)));
      cmpField("R10 abortPulse", {31'd0, abortPulse}, {31'd0, expAbort});
      cmpField("R12 busResetPulse", {31'd0, busResetPulse}, {31'd0, expBrst});
      cmpField("R2/R4 regRdData", regRdData, expRd);
    end
  end

  task automatic sync();
    @(posedge clk); #2;
  endtask

  task automatic wrReg(logic [1:0] a, logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    sync();
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rdChk(string tag, logic [1:0] a, logic [31:0] exp);
    regAddr = a; #1;
    cmpField(tag, regRdData, exp);
  endtask

  task automatic finish(logic ok, logic ib);
    cmplValid = 1'b1; cmplOk = ok; cmplIrq = ib;
    sync();
    cmplValid = 1'b0; cmplOk = 1'b0; cmplIrq = 1'b0;
  endtask

  // command write with in-cycle observation of the pulses
  task automatic command(logic [31:0] d, logic expAbort, logic expBrst, string tag);
    regWrEn = 1'b1; regAddr = 2'd0; regWrData = d; #1;
    cmpField({tag, " abortPulse"}, {31'd0, abortPulse}, {31'd0, expAbort});
    cmpField({tag, " busResetPulse"}, {31'd0, busResetPulse}, {31'd0, expBrst});
    sync();
    regWrEn = 1'b0; regWrData = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    // R1 reset state
    rdChk("R1 cmd word", 2'd0, 32'h0);
    rdChk("R1 ctrl word", 2'd1, 32'h0);
    rdChk("R1 status word", 2'd2, 32'h0);
    rdChk("R1 size word", 2'd3, 32'h0);
    cmpField("R1 reqValid", {31'd0, reqValid}, 32'h0);
    cmpField("R1 irq", {31'd0, irq}, 32'h0);

    // R2 field placement and dropped bits
    wrReg(2'd3, 32'hFFFF_FFF3);
    rdChk("R2 size keeps low field", 2'd3, 32'h3);
    wrReg(2'd1, 32'hFF00_00EE);
    rdChk("R2 ctrl drops other bits", 2'd1, 32'h0);
    wrReg(2'd1, 32'h0002_0011);
    rdChk("R2 ctrl readback", 2'd1, 32'h0002_0011);
    // R3 request offered
    cmpField("R3 pending", {31'd0, reqValid}, 32'h1);
    cmpField("R3 index", 32'(reqIndex), 32'h0);
    rdChk("R3 busy bit", 2'd2, 32'h0000_0001);

    // R5 success without interrupt flag, then with
    finish(1'b1, 1'b0);
    rdChk("R5 no flag without cmplIrq", 2'd2, 32'h0001_0001);
    finish(1'b1, 1'b1);
    rdChk("R5 done flag set, ring drained", 2'd2, 32'h0002_0020);
    cmpField("R8 irq from done", {31'd0, irq}, 32'h1);
    cmpField("R3 idle when head==tail", {31'd0, reqValid}, 32'h0);

    // R7 write-one-to-clear
    wrReg(2'd2, 32'h0);
    rdChk("R7 zero write keeps flag", 2'd2, 32'h0002_0020);
    wrReg(2'd2, 32'h20);
    rdChk("R7 one clears done", 2'd2, 32'h0002_0000);

    // R4 wrap: tail 2 -> 3 -> 0 -> 1
    wrReg(2'd1, 32'h0001_0001);
    finish(1'b1, 1'b0);
    finish(1'b1, 1'b0);
    rdChk("R4 tail wrapped to 0", 2'd2, 32'h0000_0001);
    finish(1'b1, 1'b0);
    rdChk("R4 tail reaches head", 2'd2, 32'h0001_0000);

    // R9 stray completion while idle
    finish(1'b1, 1'b1);
    rdChk("R9 ignored completion", 2'd2, 32'h0001_0000);
    cmpField("R9 no irq", {31'd0, irq}, 32'h0);

    // R6 failure stops the ring, enable gates the interrupt
    wrReg(2'd1, 32'h0003_0001);
    finish(1'b0, 1'b1);
    rdChk("R6 err set, tail moved, run cleared", 2'd2, 32'h0002_0010);
    rdChk("R6 run bit cleared", 2'd1, 32'h0003_0000);
    cmpField("R8 err masked", {31'd0, irq}, 32'h0);
    wrReg(2'd1, 32'h0003_0010);
    cmpField("R8 err enabled", {31'd0, irq}, 32'h1);
    wrReg(2'd2, 32'h10);
    cmpField("R7 err cleared", {31'd0, irq}, 32'h0);

    // R7 set wins over clear in the same cycle
    wrReg(2'd1, 32'h0003_0011);
    cmplValid = 1'b1; cmplOk = 1'b1; cmplIrq = 1'b1;
    wrReg(2'd2, 32'h20);
    cmplValid = 1'b0; cmplOk = 1'b0; cmplIrq = 1'b0;
    rdChk("R7 set beats clear", 2'd2, 32'h0003_0020);

    // R6 hardware clear of run bit beats a same-cycle software write
    wrReg(2'd2, 32'h20);
    wrReg(2'd1, 32'h0001_0011);
    cmplValid = 1'b1; cmplOk = 1'b0;
    wrReg(2'd1, 32'h0001_0011);
    cmplValid = 1'b0; cmplOk = 1'b0;
    rdChk("R6 run cleared over write", 2'd1, 32'h0001_0010);
    wrReg(2'd2, 32'h10);

    // R10 kill with a pending descriptor (tail 0, head 2)
    wrReg(2'd1, 32'h0002_0001);
    command(32'h8, 1'b1, 1'b0, "R10 kill pending");
    rdChk("R10 tail advanced, err set", 2'd2, 32'h0001_0010);
    cmpField("R10 stopped", {31'd0, reqValid}, 32'h0);
    wrReg(2'd2, 32'h10);
    command(32'h8, 1'b0, 1'b0, "R10 kill idle");
    rdChk("R10 idle kill keeps tail", 2'd2, 32'h0001_0010);

    // R12 target reset pulse leaves state alone
    command(32'h4, 1'b0, 1'b1, "R12 target reset");
    rdChk("R12 status unchanged", 2'd2, 32'h0001_0010);
    rdChk("R12 ctrl unchanged", 2'd1, 32'h0002_0000);

    // R11 soft clear beats a coincident completion
    wrReg(2'd1, 32'h0003_0011);
    cmplValid = 1'b1; cmplOk = 1'b1; cmplIrq = 1'b1;
    command(32'h40, 1'b0, 1'b0, "R11 soft clear");
    cmplValid = 1'b0; cmplOk = 1'b0; cmplIrq = 1'b0;
    rdChk("R11 ctrl zero", 2'd1, 32'h0);
    rdChk("R11 status zero", 2'd2, 32'h0);
    rdChk("R11 size zero", 2'd3, 32'h0);
    cmpField("R11 irq low", {31'd0, irq}, 32'h0);

    sync();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule